// File: doc/BRIEF.md
# Gold-Code Complex Scrambling Sequence Generator

This block produces a complex scrambling chip stream for a downlink radio frame. Each chip is a pair of bits, one for the in-phase branch and one for the quadrature branch. Each bit is the XOR of two 18-stage maximal-length shift registers. One register (the "code" register) takes its starting state from a code number. The other register (the "fixed" register) always starts from all ones. The quadrature branch is the same Gold sequence shifted ahead by a fixed 131072 chips. A second pair of registers produces it. At every frame start these registers are preloaded with the states the first pair would reach after that many steps. The jump-ahead masks are computed at elaboration from the feedback polynomial.

A frame start pulse captures the code number and restarts the sequence from chip 0. After that, the block emits one chip pair on every cycle in which the chip enable is high. Once a frame of 40960 chips is complete, all registers reload the captured code's starting states and the same frame repeats. This continues until the next frame start. The output bit is the binary chip value. The downstream modulator maps binary 0 to +1 and binary 1 to -1.

Top module: `scr_gold_gen`

## Requirements
- R1: The code register holds states s[k] = x(i+k). On a load, s[16:0] takes code number bits 16..0 and s[17] is set to 1. Each step follows x(i+18) = x(i+7) XOR x(i).
- R2: The fixed register starts from all ones on every load. Each step follows y(i+18) = y(i+10) XOR y(i+7) XOR y(i+5) XOR y(i).
- R3: The in-phase output bit for chip i is the binary value z(i) = x(i) XOR y(i). Binary 0 stands for +1 and binary 1 stands for -1.
- R4: The quadrature output bit for chip i is z(i+131072).
- R5: A frame is 40960 chips. The chip after chip 40959 is chip 0 of the same code again.
- R6: Each cycle with chip enable high after a frame start produces exactly one valid chip pair, one cycle later. A cycle with chip enable low produces no valid strobe, does not advance the sequence, and leaves the chip outputs unchanged.
- R7: The code number is sampled only in a frame start cycle. Changing it at any other time has no effect on the output.
- R8: A frame start restarts at chip 0 with the newly sampled code, even in the middle of a frame. The cycle that carries the frame start produces no valid chip, even if chip enable is high.
- R9: Bit 17 of the code number has no effect on the sequence.
- R10: Synchronous reset clears the valid strobe and both chip outputs. No valid chip appears until the first frame start after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chipEn | input | 1 | Advance by one chip this cycle |
| frameStart | input | 1 | Capture the code number and restart at chip 0 |
| codeNum | input | 18 | Scrambling code number (bit 17 ignored) |
| iChip | output | 1 | Registered in-phase binary chip |
| qChip | output | 1 | Registered quadrature binary chip |
| chipValid | output | 1 | Chip outputs updated this cycle |

## Verification
The hardest condition to reach from the ports is the frame wrap. It occurs only after 40960 enabled chips. At that point the quadrature registers must reload their jumped state, not just continue. The stimulus runs one whole frame with periodic enable gaps and continues a few hundred chips past the boundary. The quadrature branch is compared throughout against a reference that steps the two recursions 131072 times from the initial load. Mid-frame restarts follow: one while enable is high, and one with code bit 17 set.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned LFSR_W    = 18;
  localparam int unsigned FRAME_LEN = 40960;
  localparam int unsigned IQ_OFFSET = 131072;
  // Feedback terms below the top power: X^18 = X^7 + 1
  localparam logic [LFSR_W-1:0] X_TAPS = 18'h00081;
  // X^18 = X^10 + X^7 + X^5 + 1
  localparam logic [LFSR_W-1:0] Y_TAPS = 18'h004A1;

  typedef struct packed {
    logic loadNew;  // capture code and restart
    logic reload;   // end-of-frame restart with captured code
    logic step;     // emit one chip and advance
  } scrCtl_t;
endpackage

// File: rtl/scr_lfsr.sv
module scr_lfsr
  import scr_pkg::*;
#(
  parameter int unsigned W = 18,
  parameter logic [W-1:0] TAPS = '0,
  parameter int unsigned OFFSET = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  scrCtl_t      ctl,
  input  logic [W-1:0] seed,
  output logic         lsb
);
  typedef logic [W-1:0][W-1:0] mask_t;

  function automatic logic [W-1:0] timesX(logic [W-1:0] v);
    logic top;
    logic [W-1:0] r;
    top = v[W-1];
    r = v << 1;
    if (top) r = r ^ TAPS;
    return r;
  endfunction

  function automatic logic [W-1:0] mulMod(logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] r;
    r = '0;
    for (int k = W - 1; k >= 0; k--) begin
      r = timesX(r);
      if (b[k]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] powX(int unsigned e);
    logic [W-1:0] res;
    logic [W-1:0] base;
    res  = W'(1);
    base = W'(2);
    for (int b = 0; b < 32; b++) begin
      if (e[b]) res = mulMod(res, base);
      base = mulMod(base, base);
    end
    return res;
  endfunction

  // Row j: coefficients expressing x(OFFSET+j) in terms of the loaded state
  function automatic mask_t buildMasks();
    mask_t m;
    logic [W-1:0] p;
    p = powX(OFFSET);
    for (int j = 0; j < W; j++) begin
      m[j] = p;
      p = timesX(p);
    end
    return m;
  endfunction

  localparam mask_t JUMP = buildMasks();

  logic [W-1:0] st;
  logic [W-1:0] jumped;

  for (genvar j = 0; j < W; j++) begin : gJump
    assign jumped[j] = ^(JUMP[j] & seed);
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.loadNew || ctl.reload) st <= jumped;
    else if (ctl.step) st <= {^(st & TAPS), st[W-1:1]};
  end

  assign lsb = st[0];
endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 40960
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    chipEn,
  input  logic    frameStart,
  output scrCtl_t ctl,
  output logic    chipValid
);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] chipCnt;
  logic armed;
  logic lastChip;

  always_comb begin
    lastChip    = (chipCnt == LAST);
    ctl.loadNew = frameStart;
    ctl.step    = chipEn && armed && !frameStart;
    ctl.reload  = ctl.step && lastChip;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      chipCnt   <= '0;
      chipValid <= 1'b0;
    end else begin
      chipValid <= ctl.step;
      if (frameStart) begin
        armed   <= 1'b1;
        chipCnt <= '0;
      end else if (ctl.step) begin
        chipCnt <= lastChip ? '0 : chipCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scr_datapath.sv
module scr_datapath
  import scr_pkg::*;
#(
  parameter int unsigned LFSR_W = 18,
  parameter int unsigned IQ_OFFSET = 131072,
  parameter logic [LFSR_W-1:0] X_TAPS = '0,
  parameter logic [LFSR_W-1:0] Y_TAPS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  scrCtl_t           ctl,
  input  logic [LFSR_W-1:0] codeNum,
  output logic              iChip,
  output logic              qChip
);
  logic [LFSR_W-2:0] codeKept;
  logic [LFSR_W-1:0] xSeed;
  logic [1:0] xBit;
  logic [1:0] yBit;
  logic unusedCodeTop;

  assign unusedCodeTop = codeNum[LFSR_W-1];
  assign xSeed = ctl.loadNew ? {1'b1, codeNum[LFSR_W-2:0]} : {1'b1, codeKept};

  always_ff @(posedge clk) begin
    if (rst) codeKept <= '0;
    else if (ctl.loadNew) codeKept <= codeNum[LFSR_W-2:0];
  end

  // Branch 0 = in-phase (no offset), branch 1 = quadrature (jumped ahead)
  for (genvar b = 0; b < 2; b++) begin : gBranch
    localparam int unsigned OFF = (b == 0) ? 0 : IQ_OFFSET;
    scr_lfsr #(.W(LFSR_W), .TAPS(X_TAPS), .OFFSET(OFF)) uX (
      .clk(clk), .rst(rst), .ctl(ctl), .seed(xSeed), .lsb(xBit[b])
    );
    scr_lfsr #(.W(LFSR_W), .TAPS(Y_TAPS), .OFFSET(OFF)) uY (
      .clk(clk), .rst(rst), .ctl(ctl), .seed({LFSR_W{1'b1}}), .lsb(yBit[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iChip <= 1'b0;
      qChip <= 1'b0;
    end else if (ctl.step) begin
      iChip <= xBit[0] ^ yBit[0];
      qChip <= xBit[1] ^ yBit[1];
    end
  end
endmodule

// File: rtl/scr_gold_gen.sv
module scr_gold_gen
  import scr_pkg::*;
#(
  parameter int unsigned LFSR_W = scr_pkg::LFSR_W,
  parameter int unsigned FRAME_LEN = scr_pkg::FRAME_LEN,
  parameter int unsigned IQ_OFFSET = scr_pkg::IQ_OFFSET,
  parameter logic [LFSR_W-1:0] X_TAPS = scr_pkg::X_TAPS,
  parameter logic [LFSR_W-1:0] Y_TAPS = scr_pkg::Y_TAPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chipEn,
  input  logic              frameStart,
  input  logic [LFSR_W-1:0] codeNum,
  output logic              iChip,
  output logic              qChip,
  output logic              chipValid
);
  scrCtl_t ctl;

  scr_ctrl #(.FRAME_LEN(FRAME_LEN)) uCtrl (
    .clk(clk), .rst(rst), .chipEn(chipEn), .frameStart(frameStart),
    .ctl(ctl), .chipValid(chipValid)
  );

  scr_datapath #(
    .LFSR_W(LFSR_W), .IQ_OFFSET(IQ_OFFSET), .X_TAPS(X_TAPS), .Y_TAPS(Y_TAPS)
  ) uData (
    .clk(clk), .rst(rst), .ctl(ctl), .codeNum(codeNum),
    .iChip(iChip), .qChip(qChip)
  );
endmodule

// File: rtl/scr_gold_chk.sv
module scr_gold_chk (
  input logic clk,
  input logic rst,
  input logic chipEn,
  input logic frameStart,
  input logic iChip,
  input logic qChip,
  input logic chipValid
);
  logic seenStart;

  always_ff @(posedge clk) begin
    if (rst) seenStart <= 1'b0;
    else if (frameStart) seenStart <= 1'b1;
  end

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !chipEn |=> !chipValid); // R6

  AST_IDLE_HOLDS_CHIPS: assert property (@(posedge clk) disable iff (rst)
    !chipEn |=> ($stable(iChip) && $stable(qChip))); // R6

  AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    chipValid |-> $past(chipEn)); // R6

  AST_START_SILENT: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> !chipValid); // R8

  AST_NO_CHIP_BEFORE_START: assert property (@(posedge clk) disable iff (rst)
    !seenStart |-> !chipValid); // R10
endmodule

bind scr_gold_gen scr_gold_chk uChk (
  .clk(clk), .rst(rst), .chipEn(chipEn), .frameStart(frameStart),
  .iChip(iChip), .qChip(qChip), .chipValid(chipValid)
);

// File: tb/scr_gold_gen_test.sv
`timescale 1ns/1ps
module scr_gold_gen_test;
  localparam int N = 40960;
  localparam int M = 131072;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chipEn = 1'b0;
  logic frameStart = 1'b0;
  logic [17:0] codeNum = '0;
  logic iChip, qChip, chipValid;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scr_gold_gen uut (
    .clk(clk), .rst(rst), .chipEn(chipEn), .frameStart(frameStart),
    .codeNum(codeNum), .iChip(iChip), .qChip(qChip), .chipValid(chipValid)
  );

  // Reference model built from the recursions, independent of the design
  logic [17:0] mxI, myI, mxQ, myQ, ixI, ixQ, iyQ;
  logic mArmed = 0;
  int mCnt = 0;
  int emitted = 0;
  logic lastI = 0, lastQ = 0;
  logic [2:0] expQ[$];
  string tagQ[$];

  function automatic logic [17:0] xAdv(logic [17:0] s);
    return {s[7] ^ s[0], s[17:1]};
  endfunction
  function automatic logic [17:0] yAdv(logic [17:0] s);
    return {s[10] ^ s[7] ^ s[5] ^ s[0], s[17:1]};
  endfunction

  task automatic loadModel(logic [17:0] code);
    ixI = {1'b1, code[16:0]};
    ixQ = ixI;
    iyQ = '1;
    for (int i = 0; i < M; i++) begin
      ixQ = xAdv(ixQ);
      iyQ = yAdv(iyQ);
    end
    mxI = ixI; myI = '1; mxQ = ixQ; myQ = iyQ;
    mCnt = 0;
    emitted = 0;
    mArmed = 1;
  endtask

  task automatic tick(logic en, logic fs, logic [17:0] code, string tag);
    logic v;
    @(negedge clk);
    chipEn = en; frameStart = fs; codeNum = code;
    v = 0;
    if (fs) begin
      loadModel(code);
    end else if (en && mArmed) begin
      v = 1;
      lastI = mxI[0] ^ myI[0];
      lastQ = mxQ[0] ^ myQ[0];
      mxI = xAdv(mxI); myI = yAdv(myI);
      mxQ = xAdv(mxQ); myQ = yAdv(myQ);
      mCnt++;
      emitted++;
      if (mCnt == N) begin
        mCnt = 0;
        mxI = ixI; myI = '1; mxQ = ixQ; myQ = iyQ;
      end
    end
    expQ.push_back({v, lastI, lastQ});
    tagQ.push_back(tag);
  endtask

  // Monitor: one expected item per driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [2:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if ({chipValid, iChip, qChip} !== e) begin
          fails++;
          $display("FAIL %s: valid/i/q actual=%b%b%b expected=%b", t,
                   chipValid, iChip, qChip, e);
        end
      end
    end
  end

  initial begin
    #(100000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({chipValid, iChip, qChip} !== 3'b000) begin
      fails++;
      $display("FAIL R10: reset outputs actual=%b%b%b expected=000",
               chipValid, iChip, qChip);
    end
    rst = 0;

    // R10: enable without any frame start yields nothing
    for (int c = 0; c < 5; c++) tick(1, 0, 18'h00000, "R10");

    // R1 R2 R3 R4: code 0, a full frame with gaps (R6) and past the wrap (R5)
    tick(0, 1, 18'h00000, "R8");
    for (int c = 0; c < N + N / 90 + 300; c++) begin
      if (emitted < N) tick((c % 97) != 50, 0, 18'h00000, "R1 R2 R3 R4 R6");
      else tick(1, 0, 18'h00000, "R5");
    end

    // R7: code changes without a frame start
    for (int c = 0; c < 200; c++) tick(1, 0, 18'h3C3C3, "R7");

    // R8 R9: restart mid-frame with enable high, code bit 17 set
    tick(1, 1, 18'h2ABCD, "R8");
    for (int c = 0; c < 400; c++) tick(1, 0, 18'h00000, "R8 R9");

    // R1 with all-ones code bits, alternating enable (R6)
    tick(0, 1, 18'h1FFFF, "R1");
    for (int c = 0; c < 300; c++) tick(c[0], 0, 18'h00000, "R1 R6");

    tick(0, 0, 18'h00000, "R6");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule